// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 64 interrupt inputs and presents one interrupt line to a processor, along with a vector register that names the source to service. A 32-bit register port gives software control of the block. Software enables and disables sources in groups of 32 through separate set and clear registers. Each source has its own setup word, which selects edge or level sensing and assigns a priority level. When several enabled sources are pending, an arbiter chooses one.

A small service state machine governs nesting. In `ST_IDLE`, any enabled pending source can be signalled. When software reads a valid vector, the **take** transition moves the machine to `ST_SERVICE` and latches the priority of the taken source as the in-service level. In `ST_SERVICE`, only a strictly higher level reaches the processor. A further valid vector read is the **nest** transition, from `ST_SERVICE` back to `ST_SERVICE`, and it replaces the in-service level. A write to the end-of-interrupt register is the **complete** transition, from `ST_SERVICE` to `ST_IDLE`. A soft reset is the **flush** transition and returns the machine to `ST_IDLE` from either state.

The register map is as follows:

| Offset | Name | Behaviour |
|---|---|---|
| 0x00 | enable set, low | write-one-to-set for sources 0–31 |
| 0x04 | enable set, high | write-one-to-set for sources 32–63 |
| 0x08 | enable clear, low | write-one-to-clear for sources 0–31 |
| 0x0C | enable clear, high | write-one-to-clear for sources 32–63 |
| 0x10 | vector | read only |
| 0x14 | end of interrupt | write only |
| 0x18 | soft reset | write only |
| 0x1C | global enable | read/write |
| 0x100 + 8·n | setup word of source n | read/write |

All other offsets read as 0.

Top module: `ictl_top`

## Requirements
- R1: After `rst_n` is released, every enable, setup word, pending flag and the global enable are 0, `irq_o` is low, and the machine is in `ST_IDLE`.
- R2: A write of 1 to bit b of the enable-set register at 0x00 or 0x04 sets the enable of source b or 32+b. A write of 1 to bit b of the enable-clear register at 0x08 or 0x0C clears that enable. Bits written as 0 leave their enable unchanged. A read of either the set register or the clear register of a half returns that half's enable mask.
- R3: The setup word of source n sits at offset 0x100+8n. Bit 8 selects the sensing mode (1 = edge, 0 = level), and bits 3:0 hold the priority level. A read of the word returns these two fields and 0 in every other bit.
- R4: A source in level mode is pending in every cycle in which its input is high.
- R5: A source in edge mode sets a pending flag one cycle after its input rises. The flag stays set until a vector read returns that source, or until a setup write to that source clears bit 8.
- R6: Among the enabled, pending and eligible sources, the arbiter picks the one with the highest priority level. When levels are equal, the lowest index wins.
- R7: A read of the vector register at 0x10 returns the chosen index (0–63). When no source is eligible, it returns 64. Read data of every register appears in the cycle after the read strobe.
- R8: After a valid vector read, only sources whose priority level is strictly above the in-service level are eligible. This holds until a write to 0x14, whatever the data written.
- R9: `irq_o` is high exactly when bit 0 of the global-enable register at 0x1C is 1 and some source is eligible.
- R10: A write with bit 0 set to 0x18 returns every enable, setup word, pending flag, the global enable and the service state to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| src_i | input | NSRC | interrupt source inputs, synchronous to `clk` |
| bus_wr | input | 1 | single-cycle write strobe |
| bus_rd | input | 1 | single-cycle read strobe |
| bus_addr | input | ADDR_W | byte address of the register |
| bus_wdata | input | DATA_W | write data |
| bus_rdata | output | DATA_W | read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | interrupt request to the processor |

## Verification
The hardest situation to reach is an in-service level that blocks a source of equal priority while a higher-priority source still breaks through. A directed sequence builds this situation. It first takes a vector, then raises an equal-level source and a higher-level source in turn, and issues the end-of-interrupt write only afterwards. Edge flags that race with their own vector read, or with a setup write that selects level mode, come from random stimulus. The random streams toggle source inputs while reads, setup writes and enable writes are in flight, and a bench model predicts every interrupt level and every read value.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_SERVICE = 1'b1
    } svc_state_e;

    localparam logic [31:0] A_ENA_LO   = 32'h0000_0000;
    localparam logic [31:0] A_ENA_HI   = 32'h0000_0004;
    localparam logic [31:0] A_DIS_LO   = 32'h0000_0008;
    localparam logic [31:0] A_DIS_HI   = 32'h0000_000C;
    localparam logic [31:0] A_VEC      = 32'h0000_0010;
    localparam logic [31:0] A_EOI      = 32'h0000_0014;
    localparam logic [31:0] A_SRST     = 32'h0000_0018;
    localparam logic [31:0] A_GEN      = 32'h0000_001C;
    localparam logic [31:0] A_CFG_BASE = 32'h0000_0100;
    localparam int          EDGE_BIT   = 8;
endpackage

// File: rtl/ictl_src.sv
module ictl_src #(
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              src_i,
    input  logic              cfg_we,
    input  logic              cfg_edge,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              taken,
    output logic              pend_o,
    output logic              edge_o,
    output logic [PRIO_W-1:0] prio_o
);
    logic              prev_q, flag_q, edge_q;
    logic [PRIO_W-1:0] prio_q;
    logic              hit;

    assign hit = edge_q & src_i & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
            edge_q <= 1'b0;
            prio_q <= '0;
        end else if (soft_clr) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
            edge_q <= 1'b0;
            prio_q <= '0;
        end else begin
            prev_q <= src_i;
            if (cfg_we && !cfg_edge) flag_q <= 1'b0;
            else if (taken)          flag_q <= hit;
            else                     flag_q <= flag_q | hit;
            if (cfg_we) begin
                edge_q <= cfg_edge;
                prio_q <= cfg_prio;
            end
        end
    end

    assign pend_o = edge_q ? flag_q : src_i;
    assign edge_o = edge_q;
    assign prio_o = prio_q;
endmodule

// File: rtl/ictl_arb.sv
module ictl_arb #(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 4,
    parameter int VEC_W  = $clog2(NSRC) + 1
) (
    input  logic [NSRC-1:0]        elig,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    output logic [VEC_W-1:0]       vec_o,
    output logic [PRIO_W-1:0]      prio_o,
    output logic                   valid_o
);
    always_comb begin
        vec_o   = VEC_W'(NSRC);
        prio_o  = '0;
        valid_o = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i] && (!valid_o || prio_flat[i*PRIO_W +: PRIO_W] >= prio_o)) begin
                valid_o = 1'b1;
                prio_o  = prio_flat[i*PRIO_W +: PRIO_W];
                vec_o   = VEC_W'(i);
            end
        end
    end
endmodule

// File: rtl/ictl_top.sv
module ictl_top
    import ictl_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int VEC_W  = $clog2(NSRC) + 1;
    localparam int SIDX_W = $clog2(NSRC);
    localparam int HI_N   = NSRC - 32;

    logic [NSRC-1:0]        en_q, pend, edge_m, elig, take, setup_we;
    logic [NSRC*PRIO_W-1:0] prio_flat;
    logic [VEC_W-1:0]       arb_vec;
    logic [PRIO_W-1:0]      arb_prio, isl_q, isl_d;
    logic                   arb_valid, gen_q, soft_rst, take_vec, eoi_wr, in_setup;
    logic [ADDR_W-1:0]      setup_off;
    logic [SIDX_W-1:0]      sidx;
    logic [DATA_W-1:0]      rd_mux;
    svc_state_e             st_q, st_d;

    assign soft_rst  = bus_wr && bus_addr == ADDR_W'(A_SRST) && bus_wdata[0];
    assign eoi_wr    = bus_wr && bus_addr == ADDR_W'(A_EOI);
    assign take_vec  = bus_rd && bus_addr == ADDR_W'(A_VEC) && arb_valid;
    assign setup_off = bus_addr - ADDR_W'(A_CFG_BASE);
    assign in_setup  = bus_addr >= ADDR_W'(A_CFG_BASE) && setup_off < ADDR_W'(NSRC * 8)
                       && setup_off[2:0] == 3'd0;
    assign sidx      = setup_off[SIDX_W+2:3];

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign setup_we[g] = bus_wr & in_setup & (sidx == SIDX_W'(g));
        assign take[g]     = take_vec & (arb_vec == VEC_W'(g));
        ictl_src #(.PRIO_W(PRIO_W)) u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_rst),
            .src_i    (src_i[g]),
            .cfg_we   (setup_we[g]),
            .cfg_edge (bus_wdata[EDGE_BIT]),
            .cfg_prio (bus_wdata[PRIO_W-1:0]),
            .taken    (take[g]),
            .pend_o   (pend[g]),
            .edge_o   (edge_m[g]),
            .prio_o   (prio_flat[g*PRIO_W +: PRIO_W])
        );
        assign elig[g] = en_q[g] & pend[g]
                       & ((st_q == ST_IDLE) | (prio_flat[g*PRIO_W +: PRIO_W] > isl_q));
    end

    ictl_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_arb (
        .elig      (elig),
        .prio_flat (prio_flat),
        .vec_o     (arb_vec),
        .prio_o    (arb_prio),
        .valid_o   (arb_valid)
    );

    // enable masks and global enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            gen_q <= 1'b0;
        end else if (soft_rst) begin
            en_q  <= '0;
            gen_q <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(A_ENA_LO)) en_q[31:0] <= en_q[31:0] | bus_wdata[31:0];
            if (bus_addr == ADDR_W'(A_ENA_HI)) en_q[NSRC-1:32] <= en_q[NSRC-1:32] | bus_wdata[HI_N-1:0];
            if (bus_addr == ADDR_W'(A_DIS_LO)) en_q[31:0] <= en_q[31:0] & ~bus_wdata[31:0];
            if (bus_addr == ADDR_W'(A_DIS_HI)) en_q[NSRC-1:32] <= en_q[NSRC-1:32] & ~bus_wdata[HI_N-1:0];
            if (bus_addr == ADDR_W'(A_GEN))    gen_q <= bus_wdata[0];
        end
    end

    // service state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            isl_q <= '0;
        end else begin
            st_q  <= st_d;
            isl_q <= isl_d;
        end
    end

    // next state: take, nest, complete, flush
    always_comb begin
        st_d  = st_q;
        isl_d = isl_q;
        if (soft_rst) begin
            st_d  = ST_IDLE;
            isl_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (take_vec) begin
                        st_d  = ST_SERVICE;
                        isl_d = arb_prio;
                    end
                end
                ST_SERVICE: begin
                    if (take_vec) begin
                        st_d  = ST_SERVICE;
                        isl_d = arb_prio;
                    end else if (eoi_wr) begin
                        st_d  = ST_IDLE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        irq_o  = gen_q && arb_valid;
        rd_mux = '0;
        if (in_setup) begin
            rd_mux[EDGE_BIT]     = edge_m[sidx];
            rd_mux[PRIO_W-1:0]   = prio_flat[sidx*PRIO_W +: PRIO_W];
        end else if (bus_addr == ADDR_W'(A_ENA_LO) || bus_addr == ADDR_W'(A_DIS_LO)) begin
            rd_mux[31:0] = en_q[31:0];
        end else if (bus_addr == ADDR_W'(A_ENA_HI) || bus_addr == ADDR_W'(A_DIS_HI)) begin
            rd_mux[HI_N-1:0] = en_q[NSRC-1:32];
        end else if (bus_addr == ADDR_W'(A_VEC)) begin
            rd_mux[VEC_W-1:0] = arb_vec;
        end else if (bus_addr == ADDR_W'(A_GEN)) begin
            rd_mux[0] = gen_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/ictl_chk.sv
module ictl_chk
    import ictl_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic [NSRC-1:0]   en_q,
    input logic [NSRC-1:0]   pend,
    input logic              gen_q,
    input svc_state_e        st_q
);
    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_SRST) && bus_wdata[0])
        |=> (en_q == '0 && !gen_q && st_q == ST_IDLE && !irq_o));

    p_set_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_ENA_LO))
        |=> ((en_q[31:0] & $past(bus_wdata[31:0])) == $past(bus_wdata[31:0])));

    p_clr_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_DIS_LO))
        |=> ((en_q[31:0] & $past(bus_wdata[31:0])) == 32'd0));

    p_vec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(A_VEC)) |=> (bus_rdata <= DATA_W'(NSRC)));

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gen_q && (en_q & pend) != '0));

    p_gen_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_GEN) && !bus_wdata[0]) |=> !irq_o);

    p_complete_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_EOI)) |=> (st_q == ST_IDLE));
endmodule

bind ictl_top ictl_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .en_q      (en_q),
    .pend      (pend),
    .gen_q     (gen_q),
    .st_q      (st_q)
);

// File: tb/tb_ictl_top.sv
`timescale 1ns/1ps
module tb_ictl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_i = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    ictl_top dut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
                  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

    always #10 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // reference model
    bit m_en[64], m_edge[64], m_flag[64], m_prev[64];
    int m_prio[64];
    bit m_gen, m_svc;
    int m_isl;
    logic [63:0] src_v = '0;

    function automatic int cfg_addr(int n);
        return 32'h100 + 8 * n;
    endfunction

    function automatic int m_best();
        int b = 64, bp = -1;
        for (int i = 63; i >= 0; i--) begin
            bit p = m_edge[i] ? m_flag[i] : src_v[i];
            if (m_en[i] && p && (!m_svc || m_prio[i] > m_isl) && m_prio[i] >= bp) begin
                b = i; bp = m_prio[i];
            end
        end
        return b;
    endfunction

    function automatic logic [31:0] m_read(logic [31:0] a);
        logic [31:0] r = '0;
        if (a >= 32'h100 && a < 32'h300 && a[2:0] == 3'd0) begin
            int n = int'((a - 32'h100) >> 3);
            r[8] = m_edge[n]; r[3:0] = 4'(m_prio[n]);
        end else if (a == 32'h0 || a == 32'h8) begin
            for (int i = 0; i < 32; i++) r[i] = m_en[i];
        end else if (a == 32'h4 || a == 32'hC) begin
            for (int i = 0; i < 32; i++) r[i] = m_en[32 + i];
        end else if (a == 32'h10) r = 32'(m_best());
        else if (a == 32'h1C) r[0] = m_gen;
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic m_clear();
        for (int i = 0; i < 64; i++) begin
            m_en[i] = 0; m_edge[i] = 0; m_flag[i] = 0; m_prev[i] = 0; m_prio[i] = 0;
        end
        m_gen = 0; m_svc = 0; m_isl = 0;
    endtask

    task automatic step(bit wr, bit rd, logic [31:0] a, logic [31:0] d, string req);
        logic [31:0] exp_rd = '0;
        int v = 64;
        bit is_cfg;
        int cn = 0;
        @(negedge clk);
        src_i = src_v; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #1;
        chk({req, " irq"}, 32'(irq_o), 32'(m_gen && m_best() != 64));
        if (rd) exp_rd = m_read(a);
        if (wr && a == 32'h18 && d[0]) m_clear();
        else begin
            is_cfg = wr && a >= 32'h100 && a < 32'h300 && a[2:0] == 3'd0;
            if (is_cfg) cn = int'((a - 32'h100) >> 3);
            if (rd && a == 32'h10) v = m_best();
            for (int i = 0; i < 64; i++) begin
                bit st = m_edge[i] && src_v[i] && !m_prev[i];
                if (is_cfg && cn == i && !d[8]) m_flag[i] = 0;
                else if (v == i) m_flag[i] = st;
                else m_flag[i] = m_flag[i] | st;
                m_prev[i] = src_v[i];
            end
            if (v < 64) begin m_svc = 1; m_isl = m_prio[v]; end
            else if (wr && a == 32'h14) m_svc = 0;
            if (is_cfg) begin m_edge[cn] = d[8]; m_prio[cn] = int'(d[3:0]); end
            for (int i = 0; i < 32; i++) begin
                if (wr && a == 32'h0 && d[i]) m_en[i] = 1;
                if (wr && a == 32'h4 && d[i]) m_en[32 + i] = 1;
                if (wr && a == 32'h8 && d[i]) m_en[i] = 0;
                if (wr && a == 32'hC && d[i]) m_en[32 + i] = 0;
            end
            if (wr && a == 32'h1C) m_gen = d[0];
        end
        @(posedge clk);
        #1;
        bus_wr = 0; bus_rd = 0;
        if (rd) chk({req, " rdata"}, bus_rdata, exp_rd);
    endtask

    task automatic idle(string req); step(0, 0, 32'h0, 32'h0, req); endtask
    task automatic rd(logic [31:0] a, string req); step(0, 1, a, 32'h0, req); endtask
    task automatic wr(logic [31:0] a, logic [31:0] d, string req); step(1, 0, a, d, req); endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hang expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] addrs[10] = '{32'h0, 32'h4, 32'h8, 32'hC, 32'h10, 32'h1C,
                                   32'h100, 32'h178, 32'h2F8, 32'h200};
        void'($urandom(32'h5EED_0042));
        m_clear();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(32'h0, "R1"); rd(32'h4, "R1"); rd(32'h1C, "R1"); rd(cfg_addr(63), "R1");
        rd(32'h10, "R7 none pending");
        // R2 split set / clear
        wr(32'h0, 32'hF0F0_0001, "R2"); rd(32'h0, "R2");
        wr(32'h8, 32'h0000_0001, "R2"); rd(32'h8, "R2");
        wr(32'h4, 32'h8000_0101, "R2"); rd(32'hC, "R2");
        wr(32'hC, 32'h0000_0001, "R2"); rd(32'h4, "R2");
        // R3 setup readback, junk bits masked
        wr(cfg_addr(5), 32'hFFF0_F107, "R3"); rd(cfg_addr(5), "R3");
        wr(cfg_addr(5), 32'h0000_0000, "R3"); rd(cfg_addr(5), "R3");
        // R4 / R9 level source and global enable
        wr(32'h0, 32'h0000_1084, "R4");
        src_v[2] = 1; idle("R9 gen off");
        wr(32'h1C, 32'h1, "R9"); idle("R4 level high");
        src_v[2] = 0; idle("R4 level low");
        // R6 tie and priority, R8 in-service threshold
        wr(cfg_addr(2), 32'h3, "R6"); wr(cfg_addr(7), 32'h3, "R6"); wr(cfg_addr(12), 32'h9, "R6");
        src_v[2] = 1; src_v[7] = 1; idle("R6");
        rd(32'h10, "R6 tie lowest index");
        idle("R8 equal level blocked");
        src_v[12] = 1; idle("R8 higher level passes");
        rd(32'h10, "R8 nested take");
        src_v[12] = 0; idle("R8 masked below");
        wr(32'h14, 32'hDEAD_BEEF, "R8 complete"); idle("R8 after complete");
        rd(32'h10, "R6"); wr(32'h14, 32'h0, "R8");
        src_v[2] = 0; src_v[7] = 0;
        // R5 edge latch
        wr(cfg_addr(40), 32'h101, "R5"); wr(32'h4, 32'h100, "R5");
        src_v[40] = 1; idle("R5 rise"); src_v[40] = 0; idle("R5 latched");
        rd(32'h10, "R5 take"); wr(32'h14, 0, "R5"); rd(32'h10, "R5 cleared");
        wr(32'h14, 0, "R5");
        src_v[40] = 1; idle("R5"); src_v[40] = 0; idle("R5");
        wr(cfg_addr(40), 32'h001, "R5 level clears"); rd(32'h10, "R5");
        // R10 soft reset
        wr(32'h18, 32'h1, "R10"); rd(32'h0, "R10"); rd(32'h1C, "R10"); rd(cfg_addr(5), "R10");
        // random mix
        wr(32'h1C, 32'h1, "R9");
        for (int k = 0; k < 4000; k++) begin
            int op = $urandom % 16;
            if ($urandom % 2) src_v[$urandom % 64] ^= 1'b1;
            case (op)
                0, 1:    wr(($urandom % 2) ? 32'h0 : 32'h4, $urandom, "R2 random");
                2:       wr(($urandom % 2) ? 32'h8 : 32'hC, $urandom & $urandom, "R2 random");
                3, 4:    wr(cfg_addr($urandom % 64), $urandom & 32'hFFFF_F10F, "R3 random");
                5, 6, 7: rd(32'h10, "R7 random");
                8:       wr(32'h14, $urandom, "R8 random");
                9:       wr(32'h1C, 32'(($urandom % 8) != 0), "R9 random");
                10, 11:  rd(addrs[$urandom % 10], "R3 random read");
                12:      if ($urandom % 40 == 0) wr(32'h18, 32'h1, "R10 random");
                         else idle("R4 random");
                default: idle("R9 random");
            endcase
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule